// File: doc/BRIEF.md
# Processor Status Register Unit

This unit keeps the processor's live status word and one saved copy per exception mode. The status word holds four condition flags (negative, zero, carry, overflow), the two interrupt masks and a five-bit mode field. The rest of the core reads the flags, masks and mode straight from dedicated output pins.

Four kinds of request can change the state. The ALU presents a result with a set-flags qualifier. An exception-entry strobe saves the live word and switches mode. An exception-return strobe restores the live word from the saved copy of the current mode. Move-to-status writes go to either the live word or the current mode's saved copy. A move-from-status read port returns either of the two words combinationally.

Every request pin is a plain strobe that is sampled on each rising clock edge. No interface applies back-pressure: each request is accepted or dropped in the cycle it is presented, according to the fixed priority in R10. All state changes become visible one clock after the request.

Top module: `psr_unit`

## Requirements
- R1: The live word places N at bit 31, Z at bit 30, C at bit 29, V at bit 28, the IRQ mask I at bit 7, the FIQ mask F at bit 6 and the mode at bits 4..0. Every other bit of the live word, the saved words and the read port is zero.
- R2: While reset (rst_n low) is asserted, the live word is 32'h000000D3: supervisor mode 5'h13, I=1, F=1, flags clear. All saved words are zero.
- R3: When alu_valid and alu_setf are both high and no higher-priority request is present, the next cycle shows N = alu_result[31], Z = (alu_result == 0), C = alu_carry and V = alu_ovf. The other bits are unchanged.
- R4: A result presented without the qualifier, or with alu_valid low, leaves the live word unchanged.
- R5: Exception entry copies the live word into the saved word of exc_mode, writes exc_mode into the mode field and sets I. F is also set when exc_mode is FIQ. Valid targets are FIQ 5'h11, IRQ 5'h12, supervisor 5'h13, abort 5'h17 and undefined 5'h1B. An entry request with any other code changes nothing.
- R6: Exception return replaces the live word with the saved word of the current mode in one cycle. In user mode (5'h10), system mode (5'h1F) or any mode without a saved word, it changes nothing.
- R7: In a mode without a saved word, a read of the saved word (sr_rd_sel=1) returns the live word, and a write to it (sr_wr_sel=1) is ignored.
- R8: In user mode, a write to the live word changes only bits 31..28.
- R9: In any other mode, a write to the live word loads bits 31..28, 7 and 6. It loads the mode field only if the written code is one of the seven legal modes (the five above, 5'h10 and 5'h1F). Otherwise the mode is kept.
- R10: Priority, highest first: entry, return, live-word write, ALU flag update. An asserted higher request suppresses all lower ones, even when it is itself ignored. A saved-word write is suppressed by entry or return but not by the ALU update.
- R11: In an exception mode, a saved-word write stores the data with reserved bits cleared, and a saved-word read returns that stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_valid | input | 1 | ALU result present |
| alu_setf | input | 1 | Set-flags qualifier |
| alu_result | input | 32 | ALU result word |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU overflow |
| exc_enter | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target exception mode |
| exc_return | input | 1 | Exception return strobe |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_sel | input | 1 | Write target: 0 live, 1 saved |
| sr_wr_data | input | 32 | Status write data |
| sr_rd_sel | input | 1 | Read source: 0 live, 1 saved |
| sr_rd_data | output | 32 | Status read data |
| cpsr_out | output | 32 | Live status word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_mask | output | 1 | IRQ mask |
| fiq_mask | output | 1 | FIQ mask |
| cur_mode | output | 5 | Current mode |

## Verification
A corrupt live word shows up on cpsr_out and the flag pins one clock after the faulty update. A corrupt saved word stays hidden until it is read back through sr_rd_data in its own mode, or until an exception return copies it onto cpsr_out. For this reason the stimulus keeps moving between modes, reading saved words and returning from exceptions. A behavioural model compares both output words and every flag pin on every cycle, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam int BIT_N = 31;
  localparam int BIT_Z = 30;
  localparam int BIT_C = 29;
  localparam int BIT_V = 28;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;

  localparam logic [PSR_W-1:0] FLAG_MASK = 32'hF000_0000;
  localparam logic [PSR_W-1:0] MASK_BITS = 32'h0000_00C0;
  localparam logic [PSR_W-1:0] MODE_MASK = 32'h0000_001F;
  localparam logic [PSR_W-1:0] LIVE_MASK = FLAG_MASK | MASK_BITS | MODE_MASK;
  localparam logic [PSR_W-1:0] RESET_PSR = 32'h0000_00D3;

  typedef logic [MODE_W-1:0] mode_t;

  // Bank slot order: supervisor, abort, undefined, irq, fiq
  function automatic mode_t bank_code(input int idx);
    case (idx)
      0:       return MODE_SVC;
      1:       return MODE_ABT;
      2:       return MODE_UND;
      3:       return MODE_IRQ;
      default: return MODE_FIQ;
    endcase
  endfunction

  function automatic logic mode_legal(input mode_t m);
    return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
           (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
           (m == MODE_SYS);
  endfunction
endpackage

// File: rtl/psr_mode_dec.sv
module psr_mode_dec
  import psr_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  mode_t         mode,
  output logic [NB-1:0] bank_hit,
  output logic          has_bank,
  output logic          legal
);
  for (genvar i = 0; i < NB; i++) begin : g_hit
    assign bank_hit[i] = (mode == bank_code(i));
  end
  assign has_bank = |bank_hit;
  assign legal    = mode_legal(mode);
endmodule

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int W = PSR_W
) (
  input  logic [W-1:0] result,
  input  logic         carry,
  input  logic         ovf,
  output logic [3:0]   nzcv
);
  assign nzcv = {result[W-1], (result == '0), carry, ovf};
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int W  = PSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] save_sel,
  input  logic [W-1:0]  save_data,
  input  logic [NB-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [NB-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] slot_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)           slot_q[i] <= '0;
      else if (save_sel[i]) slot_q[i] <= save_data;
      else if (wr_sel[i])   slot_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NB; i++)
      if (rd_sel[i]) rd_data = rd_data | slot_q[i];
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alu_valid,
  input  logic        alu_setf,
  input  logic [31:0] alu_result,
  input  logic        alu_carry,
  input  logic        alu_ovf,
  input  logic        exc_enter,
  input  logic [4:0]  exc_mode,
  input  logic        exc_return,
  input  logic        sr_wr_en,
  input  logic        sr_wr_sel,
  input  logic [31:0] sr_wr_data,
  input  logic        sr_rd_sel,
  output logic [31:0] sr_rd_data,
  output logic [31:0] cpsr_out,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v,
  output logic        irq_mask,
  output logic        fiq_mask,
  output logic [4:0]  cur_mode
);
  localparam int NB = NUM_BANKS;
  localparam int W  = PSR_W;

  logic [W-1:0]  cpsr_q, cpsr_d;
  logic [NB-1:0] cur_hit, tgt_hit, wr_hit_unused;
  logic          cur_banked, cur_legal_unused;
  logic          tgt_banked, tgt_legal_unused;
  logic          wr_banked_unused, wr_mode_ok;
  logic [NB-1:0] bank_save, bank_wr;
  logic [W-1:0]  saved_cur;
  logic [3:0]    alu_nzcv;
  logic          in_user;

  psr_mode_dec #(.NB(NB)) u_cur_dec (
    .mode(cpsr_q[4:0]), .bank_hit(cur_hit),
    .has_bank(cur_banked), .legal(cur_legal_unused));

  psr_mode_dec #(.NB(NB)) u_tgt_dec (
    .mode(exc_mode), .bank_hit(tgt_hit),
    .has_bank(tgt_banked), .legal(tgt_legal_unused));

  psr_mode_dec #(.NB(NB)) u_wr_dec (
    .mode(sr_wr_data[4:0]), .bank_hit(wr_hit_unused),
    .has_bank(wr_banked_unused), .legal(wr_mode_ok));

  psr_flag_calc #(.W(W)) u_flags (
    .result(alu_result), .carry(alu_carry), .ovf(alu_ovf), .nzcv(alu_nzcv));

  psr_bank #(.NB(NB), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .save_sel(bank_save), .save_data(cpsr_q),
    .wr_sel(bank_wr), .wr_data(sr_wr_data & LIVE_MASK),
    .rd_sel(cur_hit), .rd_data(saved_cur));

  assign in_user = (cpsr_q[4:0] == MODE_USR);

  always_comb begin
    cpsr_d    = cpsr_q;
    bank_save = '0;
    bank_wr   = '0;
    if (exc_enter) begin
      if (tgt_banked) begin
        bank_save       = tgt_hit;
        cpsr_d[4:0]     = exc_mode;
        cpsr_d[BIT_I]   = 1'b1;
        if (exc_mode == MODE_FIQ) cpsr_d[BIT_F] = 1'b1;
      end
    end else if (exc_return) begin
      if (cur_banked) cpsr_d = saved_cur;
    end else begin
      if (sr_wr_en && sr_wr_sel && cur_banked) bank_wr = cur_hit;
      if (sr_wr_en && !sr_wr_sel) begin
        cpsr_d[31:28] = sr_wr_data[31:28];
        if (!in_user) begin
          cpsr_d[BIT_I] = sr_wr_data[BIT_I];
          cpsr_d[BIT_F] = sr_wr_data[BIT_F];
          if (wr_mode_ok) cpsr_d[4:0] = sr_wr_data[4:0];
        end
      end else if (alu_valid && alu_setf) begin
        cpsr_d[31:28] = alu_nzcv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpsr_q <= RESET_PSR;
    else        cpsr_q <= cpsr_d & LIVE_MASK;
  end

  assign sr_rd_data = (sr_rd_sel && cur_banked) ? saved_cur : cpsr_q;
  assign cpsr_out   = cpsr_q;
  assign flag_n     = cpsr_q[BIT_N];
  assign flag_z     = cpsr_q[BIT_Z];
  assign flag_c     = cpsr_q[BIT_C];
  assign flag_v     = cpsr_q[BIT_V];
  assign irq_mask   = cpsr_q[BIT_I];
  assign fiq_mask   = cpsr_q[BIT_F];
  assign cur_mode   = cpsr_q[4:0];
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
  import psr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        alu_valid,
  input logic        alu_setf,
  input logic [31:0] alu_result,
  input logic        exc_enter,
  input logic [4:0]  exc_mode,
  input logic        exc_return,
  input logic        sr_wr_en,
  input logic        sr_wr_sel,
  input logic        sr_rd_sel,
  input logic [31:0] sr_rd_data,
  input logic [31:0] cpsr_out,
  input logic        flag_n,
  input logic        flag_z,
  input logic        irq_mask,
  input logic [4:0]  cur_mode
);
  logic live_wr;
  logic tgt_ok;
  assign live_wr = sr_wr_en && !sr_wr_sel;
  assign tgt_ok  = (exc_mode == MODE_FIQ) || (exc_mode == MODE_IRQ) ||
                   (exc_mode == MODE_SVC) || (exc_mode == MODE_ABT) ||
                   (exc_mode == MODE_UND);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpsr_out & ~LIVE_MASK) == '0) && ((sr_rd_data & ~LIVE_MASK) == '0));

  assert_flag_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_setf && !exc_enter && !exc_return && !live_wr)
    |=> (flag_n == $past(alu_result[31])) && (flag_z == ($past(alu_result) == '0)));

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alu_valid && alu_setf) && !exc_enter && !exc_return && !live_wr)
    |=> $stable(cpsr_out));

  assert_entry_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && tgt_ok) |=> irq_mask && (cur_mode == $past(exc_mode)));

  assert_no_saved_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_sel && ((cur_mode == MODE_USR) || (cur_mode == MODE_SYS)))
    |-> (sr_rd_data == cpsr_out));

  assert_user_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_USR) && live_wr && !exc_enter && !exc_return)
    |=> (cur_mode == MODE_USR) && $stable(cpsr_out[7:0]));
endmodule

bind psr_unit psr_unit_chk u_chk (.*);

// File: tb/sim_psr_unit.sv
`timescale 1ns/1ps
module sim_psr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_valid = 0, alu_setf = 0, alu_carry = 0, alu_ovf = 0;
  logic [31:0] alu_result = '0;
  logic        exc_enter = 0, exc_return = 0;
  logic [4:0]  exc_mode = '0;
  logic        sr_wr_en = 0, sr_wr_sel = 0, sr_rd_sel = 0;
  logic [31:0] sr_wr_data = '0;
  logic [31:0] sr_rd_data, cpsr_out;
  logic        flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask;
  logic [4:0]  cur_mode;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] m_cpsr;
  logic [31:0] m_saved [0:31];
  string       m_tag;

  always #5 clk = ~clk;

  psr_unit u0 (.*);

  function automatic bit is_exc(input logic [4:0] m);
    return m inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
  endfunction
  function automatic bit is_legal(input logic [4:0] m);
    return is_exc(m) || m == 5'h10 || m == 5'h1F;
  endfunction

  task automatic model_step();
    logic [4:0] md = m_cpsr[4:0];
    if (exc_enter) begin
      m_tag = "R5";
      if (is_exc(exc_mode)) begin
        m_saved[exc_mode] = m_cpsr;
        m_cpsr[4:0] = exc_mode;
        m_cpsr[7] = 1'b1;
        if (exc_mode == 5'h11) m_cpsr[6] = 1'b1;
      end
    end else if (exc_return) begin
      m_tag = "R6";
      if (is_exc(md)) m_cpsr = m_saved[md];
    end else begin
      m_tag = "R4";
      if (sr_wr_en && sr_wr_sel) begin
        m_tag = is_exc(md) ? "R11" : "R7";
        if (is_exc(md)) m_saved[md] = sr_wr_data & 32'hF00000DF;
      end
      if (sr_wr_en && !sr_wr_sel) begin
        m_cpsr[31:28] = sr_wr_data[31:28];
        if (md == 5'h10) m_tag = "R8";
        else begin
          m_tag = "R9";
          m_cpsr[7:6] = sr_wr_data[7:6];
          if (is_legal(sr_wr_data[4:0])) m_cpsr[4:0] = sr_wr_data[4:0];
        end
      end else if (alu_valid && alu_setf) begin
        if (m_tag == "R4") m_tag = "R3";
        m_cpsr[31] = alu_result[31];
        m_cpsr[30] = (alu_result == 0);
        m_cpsr[29] = alu_carry;
        m_cpsr[28] = alu_ovf;
      end
    end
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] exp_rd;
    exp_rd = (sr_rd_sel && is_exc(m_cpsr[4:0])) ? m_saved[m_cpsr[4:0]] : m_cpsr;
    cmp(tag, cpsr_out, m_cpsr);
    cmp(tag, sr_rd_data, exp_rd);
    cmp(tag, {24'd0, flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask, 2'b00},
             {24'd0, m_cpsr[31:28], m_cpsr[7:6], 2'b00});
    cmp(tag, {27'd0, cur_mode}, {27'd0, m_cpsr[4:0]});
    cmp("R1", cpsr_out & 32'h0FFFFF20, 32'd0);
  endtask

  task automatic step(input bit en, input logic [4:0] em, input bit rt,
                      input bit we, input bit ws, input logic [31:0] wd, input bit rs,
                      input bit av, input bit sf, input logic [31:0] res,
                      input bit c, input bit v, input string note);
    exc_enter = en; exc_mode = em; exc_return = rt;
    sr_wr_en = we; sr_wr_sel = ws; sr_wr_data = wd; sr_rd_sel = rs;
    alu_valid = av; alu_setf = sf; alu_result = res; alu_carry = c; alu_ovf = v;
    model_step();
    if (note != "") m_tag = note;
    @(negedge clk);
    check_all(m_tag);
  endtask

  initial begin
    #1ms;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    m_cpsr = 32'h000000D3;
    for (int i = 0; i < 32; i++) m_saved[i] = '0;
    repeat (3) @(negedge clk);
    sr_rd_sel = 1'b1;
    #1 check_all("R2");
    rst_n = 1'b1;
    // flags from ALU
    step(0,0,0, 0,0,0,1, 1,1,32'h8000_0000,1,0, "R3");
    step(0,0,0, 0,0,0,0, 1,0,32'h0,0,1, "R4");
    step(0,0,0, 0,0,0,0, 0,1,32'h0,0,1, "R4");
    step(0,0,0, 0,0,0,0, 1,1,32'h0,0,1, "R3");
    // supervisor saved write, then drop to user
    step(0,0,0, 1,1,32'hFFFF_FFFF,1, 0,0,0,0,0, "R11");
    step(0,0,0, 1,0,32'h0000_0010,0, 0,0,0,0,0, "R9");
    step(0,0,0, 1,1,32'hA000_0013,1, 0,0,0,0,0, "R7");
    step(0,0,0, 1,0,32'hFFFF_FFFF,0, 1,1,32'h1,1,1, "R8");
    step(0,0,1, 0,0,0,1, 0,0,0,0,0, "R6");
    step(1,5'h12,0, 0,0,0,1, 0,0,0,0,0, "R5");
    step(1,5'h10,0, 0,0,0,1, 1,1,32'h0,1,1, "R5");
    step(1,5'h11,1, 1,0,32'h0,1, 1,1,32'h0,0,0, "R10");
    step(0,0,0, 1,1,32'hFFFF_FFFF,1, 1,1,32'h4,0,0, "R11");
    step(0,0,1, 1,0,32'h0,1, 1,1,32'h0,0,0, "R10");
    step(0,0,0, 1,0,32'h5000_0005,1, 0,0,0,0,0, "R9");
    step(1,5'h17,0, 0,0,0,1, 0,0,0,0,0, "R5");
    step(0,0,1, 0,0,0,1, 0,0,0,0,0, "R6");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [4:0] em;
      logic [31:0] wd;
      case ($urandom_range(0, 7))
        0: em = 5'h11; 1: em = 5'h12; 2: em = 5'h13; 3: em = 5'h17;
        4: em = 5'h1B; 5: em = 5'h10; 6: em = 5'h1F; default: em = 5'($urandom);
      endcase
      wd = $urandom;
      if ($urandom_range(0, 3) != 0) begin
        case ($urandom_range(0, 6))
          0: wd[4:0] = 5'h10; 1: wd[4:0] = 5'h1F; 2: wd[4:0] = 5'h12;
          3: wd[4:0] = 5'h13; 4: wd[4:0] = 5'h11; 5: wd[4:0] = 5'h1B;
          default: wd[4:0] = 5'h17;
        endcase
      end
      step(r < 8, em, (r >= 8 && r < 16) || r == 3, r >= 40 && r < 70,
           1'($urandom), wd, 1'($urandom),
           1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom,
           1'($urandom), 1'($urandom), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule